// File: doc/BRIEF.md
# Dual-Word DDS Core with I/Q Amplitude Scaling

This block is a pipelined direct digital synthesis core. A 32-bit phase accumulator advances on every clock by one of two frequency tuning words. A single select input chooses which word is used. A 12-bit phase offset is added to the top of the accumulator, and the resulting 12-bit phase addresses a sine/cosine lookup. The lookup is a quarter-wave ROM that is filled at elaboration by a function. The block then produces a signed 10-bit sample for a DAC. It outputs either the sine directly or the sum of the sine and cosine, each scaled by its own signed fraction, which gives AM or QAM.

The control and data inputs (select, both tuning words, offset, modulation word) either pass through a four-stage synchronizer or bypass it. Every latency is fixed, and bypassing the synchronizer shortens each latency by exactly four cycles. A sleep input freezes the accumulator and holds the output at zero. The host register file and the analog converter sit outside the block.

Top module: `dds_iq_synth`

## Requirements
- R1: Synchronous active-high reset clears every register, including the accumulator and the synchronizer, so `dac_out` is 0 during reset and in the first cycle after it.
- R2: When not asleep, the accumulator adds the selected tuning word on every clock, modulo 2^32. `fsel`=0 selects `tword0` and `fsel`=1 selects `tword1`.
- R3: The lookup phase is the top 12 bits of the accumulator plus `phase_ofs`, modulo 4096.
- R4: For phase a, let h = a mod 2048, u = 2h+1 and m = floor(4·u·(4096−u)·511 / 4096²). The sine is −m when a ≥ 2048, otherwise m. The cosine of a equals the sine of (a+1024) mod 4096.
- R5: With `mod_en`=0, `dac_out` is the sine in two's complement.
- R6: With `mod_en`=1, `dac_out` = floor((sin·Q + cos·I) / 512) saturated to [−512, 511]. Q is `iq_word[19:10]` and I is `iq_word[9:0]`, both signed two's complement.
- R7: An input `sleep`=1 sampled at a clock edge keeps the accumulator unchanged at that edge and makes `dac_out` 0 after that edge.
- R8: With `sync_bypass`=1, a change to `fsel` or to a tuning word first shows on `dac_out` at the 10th rising edge, counting the edge that samples it as the first. For `phase_ofs` this is the 9th edge, and for `iq_word` the 7th.
- R9: With `sync_bypass`=0, each latency in R8 grows by exactly 4 edges (14, 13 and 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_bypass | input | 1 | 1 routes the control/data bundle around the 4-stage synchronizer |
| sleep | input | 1 | 1 freezes the accumulator and forces the output to zero |
| mod_en | input | 1 | 1 enables the I/Q scaled sum, 0 outputs the plain sine |
| fsel | input | 1 | Tuning word select |
| tword0 | input | 32 | Tuning word used when `fsel`=0 |
| tword1 | input | 32 | Tuning word used when `fsel`=1 |
| phase_ofs | input | 12 | Phase offset added to the accumulator top bits |
| iq_word | input | 20 | Signed fractions: [19:10] scale sine, [9:0] scale cosine |
| dac_out | output | 10 | Signed output sample |

## Verification
Four properties are checked on every cycle. The accumulator holds during sleep, and the output reads zero the cycle after sleep is sampled. The lookup's sign agrees with the half of the phase circle that the address lies in. In non-modulated mode the output equals the lookup sine from five cycles earlier. The bench's scenarios cover everything that depends on value and timing as a whole. This covers the exact stage at which a select, offset or modulation change lands in both synchronizer settings, the accumulator wrap, the table contents, and the saturation limits under extreme fractions. These are shown by comparing every output sample against a cycle-indexed model built from the latencies and formulas above.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int DEF_ACC_W  = 32;
  localparam int DEF_PH_W   = 12;
  localparam int DEF_AMP_W  = 10;
  localparam int DEF_IQ_W   = 10;
  localparam int DEF_SYNC_N = 4;

  // Parabolic quarter-wave magnitude for entry idx of a table that spans
  // a quarter of a circle addressed with ph_w bits.
  function automatic logic [15:0] quarter_mag(input int idx, input int ph_w, input int amp_w);
    longint span;
    longint u;
    longint peak;
    longint num;
    span = longint'(1) << ph_w;
    u    = 2 * longint'(idx) + 1;
    peak = (longint'(1) << (amp_w - 1)) - 1;
    num  = 4 * u * (span - u) * peak;
    return 16'(num / (span * span));
  endfunction

endpackage

// File: rtl/dds_ctrl_sync.sv
module dds_ctrl_sync #(
  parameter int W      = 8,
  parameter int STAGES = dds_pkg::DEF_SYNC_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bypass,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_none
      assign dout = din;
    end else begin : g_pipe
      logic [STAGES-1:0][W-1:0] stg;

      always_ff @(posedge clk) begin
        if (rst) begin
          stg <= '0;
        end else begin
          stg[0] <= din;
          for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
      end

      assign dout = bypass ? din : stg[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/dds_phase.sv
module dds_phase #(
  parameter int ACC_W = dds_pkg::DEF_ACC_W,
  parameter int PH_W  = dds_pkg::DEF_PH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep,
  input  logic             fsel,
  input  logic [ACC_W-1:0] word0,
  input  logic [ACC_W-1:0] word1,
  input  logic [PH_W-1:0]  ofs,
  output logic [PH_W-1:0]  ph
);

  logic [ACC_W-1:0] tw_q;
  logic [ACC_W-1:0] acc_q;
  logic [PH_W-1:0]  ofs_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tw_q  <= '0;
      acc_q <= '0;
      ofs_q <= '0;
      ph_q  <= '0;
    end else begin
      tw_q  <= fsel ? word1 : word0;
      ofs_q <= ofs;
      if (!sleep) acc_q <= acc_q + tw_q;
      ph_q  <= acc_q[ACC_W-1 -: PH_W] + ofs_q;
    end
  end

  assign ph = ph_q;

  // R7: accumulator is frozen on any edge that samples sleep high
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (acc_q == $past(acc_q)));

endmodule

// File: rtl/dds_sincos_lut.sv
module dds_sincos_lut #(
  parameter int PH_W  = dds_pkg::DEF_PH_W,
  parameter int AMP_W = dds_pkg::DEF_AMP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PH_W-1:0]         ph,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);

  localparam int QW     = PH_W - 2;
  localparam int QDEPTH = 1 << QW;
  localparam int MAG_W  = AMP_W - 1;

  logic [MAG_W-1:0] rom [QDEPTH];

  initial begin
    for (int i = 0; i < QDEPTH; i++) rom[i] = MAG_W'(dds_pkg::quarter_mag(i, PH_W, AMP_W));
  end

  logic [1:0]    quad_s, quad_c;
  logic [QW-1:0] idx_s, idx_c;

  always_comb begin
    quad_s = ph[PH_W-1 -: 2];
    quad_c = quad_s + 2'd1;
    idx_s  = quad_s[0] ? ~ph[QW-1:0] : ph[QW-1:0];
    idx_c  = quad_c[0] ? ~ph[QW-1:0] : ph[QW-1:0];
  end

  // Two read ports on one table, registered without reset for RAM inference
  logic [MAG_W-1:0] mag_s, mag_c;
  always_ff @(posedge clk) begin
    mag_s <= rom[idx_s];
    mag_c <= rom[idx_c];
  end

  logic neg_s, neg_c;
  logic signed [AMP_W-1:0] sin_q, cos_q;
  logic signed [AMP_W-1:0] ms, mc;

  assign ms = signed'({1'b0, mag_s});
  assign mc = signed'({1'b0, mag_c});

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_s <= 1'b0;
      neg_c <= 1'b0;
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      neg_s <= quad_s[1];
      neg_c <= quad_c[1];
      sin_q <= neg_s ? -ms : ms;
      cos_q <= neg_c ? -mc : mc;
    end
  end

  assign sin_o = sin_q;
  assign cos_o = cos_q;

  // R4: sign of the looked-up values follows the half-circle of the address
  assert_sin_sign_R4: assert property (@(posedge clk) disable iff (rst)
    ph[PH_W-1] |-> ##2 (sin_q <= 0));
  assert_sin_pos_R4: assert property (@(posedge clk) disable iff (rst)
    !ph[PH_W-1] |-> ##2 (sin_q >= 0));
  assert_cos_sign_R4: assert property (@(posedge clk) disable iff (rst)
    quad_c[1] |-> ##2 (cos_q <= 0));

endmodule

// File: rtl/dds_iq_mod.sv
module dds_iq_mod #(
  parameter int AMP_W = dds_pkg::DEF_AMP_W,
  parameter int IQ_W  = dds_pkg::DEF_IQ_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep,
  input  logic                    mod_en,
  input  logic signed [AMP_W-1:0] sin_i,
  input  logic signed [AMP_W-1:0] cos_i,
  input  logic [2*IQ_W-1:0]       iq,
  output logic [AMP_W-1:0]        dout
);

  localparam int PROD_W = AMP_W + IQ_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int SHIFT  = IQ_W - 1;
  localparam int BYP_N  = 3;
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((1 << (AMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = -HI - 1;

  logic [2*IQ_W-1:0]        iq_d1, iq_d2;
  logic signed [AMP_W-1:0]  op_s, op_c;
  logic signed [IQ_W-1:0]   op_q, op_i;
  logic signed [PROD_W-1:0] pr_s, pr_c;
  logic signed [SUM_W-1:0]  sum_q, scaled;
  logic signed [AMP_W-1:0]  sat_n, sat_q;
  logic [BYP_N-1:0][AMP_W-1:0] byp;
  logic [AMP_W-1:0]         dout_q;

  assign scaled = sum_q >>> SHIFT;

  always_comb begin
    if (scaled > HI)      sat_n = HI[AMP_W-1:0];
    else if (scaled < LO) sat_n = LO[AMP_W-1:0];
    else                  sat_n = scaled[AMP_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iq_d1  <= '0;
      iq_d2  <= '0;
      op_s   <= '0;
      op_c   <= '0;
      op_q   <= '0;
      op_i   <= '0;
      pr_s   <= '0;
      pr_c   <= '0;
      sum_q  <= '0;
      sat_q  <= '0;
      byp    <= '0;
      dout_q <= '0;
    end else begin
      iq_d1  <= iq;
      iq_d2  <= iq_d1;
      op_s   <= sin_i;
      op_c   <= cos_i;
      op_q   <= iq_d2[2*IQ_W-1:IQ_W];
      op_i   <= iq_d2[IQ_W-1:0];
      pr_s   <= op_s * op_q;
      pr_c   <= op_c * op_i;
      sum_q  <= pr_s + pr_c;
      sat_q  <= sat_n;
      byp[0] <= op_s;
      for (int b = 1; b < BYP_N; b++) byp[b] <= byp[b-1];
      if (sleep)       dout_q <= '0;
      else if (mod_en) dout_q <= sat_q;
      else             dout_q <= byp[BYP_N-1];
    end
  end

  assign dout = dout_q;

  // Cycles since reset, used only to keep $past inside the reset-free window
  logic [2:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)              warm_q <= '0;
    else if (warm_q != '1) warm_q <= warm_q + 3'd1;
  end

  // R7: output idles the cycle after sleep is sampled
  assert_sleep_idle_R7: assert property (@(posedge clk) disable iff (rst)
    sleep |=> (dout == '0));

  // R5: plain mode passes the incoming sine through a fixed five-cycle path
  assert_bypass_path_R5: assert property (@(posedge clk) disable iff (rst)
    (warm_q == '1 && !sleep && !mod_en) |=> (dout == $past(sin_i, 5)));

endmodule

// File: rtl/dds_iq_synth.sv
module dds_iq_synth #(
  parameter int ACC_W  = dds_pkg::DEF_ACC_W,
  parameter int PH_W   = dds_pkg::DEF_PH_W,
  parameter int AMP_W  = dds_pkg::DEF_AMP_W,
  parameter int IQ_W   = dds_pkg::DEF_IQ_W,
  parameter int SYNC_N = dds_pkg::DEF_SYNC_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_bypass,
  input  logic              sleep,
  input  logic              mod_en,
  input  logic              fsel,
  input  logic [ACC_W-1:0]  tword0,
  input  logic [ACC_W-1:0]  tword1,
  input  logic [PH_W-1:0]   phase_ofs,
  input  logic [2*IQ_W-1:0] iq_word,
  output logic [AMP_W-1:0]  dac_out
);

  localparam int BUNDLE_W = 1 + 2 * ACC_W + PH_W + 2 * IQ_W;

  logic [BUNDLE_W-1:0] bundle_raw, bundle_eff;
  logic                s_fsel;
  logic [ACC_W-1:0]    s_w0, s_w1;
  logic [PH_W-1:0]     s_ofs;
  logic [2*IQ_W-1:0]   s_iq;

  assign bundle_raw = {fsel, tword1, tword0, phase_ofs, iq_word};
  assign {s_fsel, s_w1, s_w0, s_ofs, s_iq} = bundle_eff;

  dds_ctrl_sync #(.W(BUNDLE_W), .STAGES(SYNC_N)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .bypass (sync_bypass),
    .din    (bundle_raw),
    .dout   (bundle_eff)
  );

  logic [PH_W-1:0] ph;

  dds_phase #(.ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
    .clk   (clk),
    .rst   (rst),
    .sleep (sleep),
    .fsel  (s_fsel),
    .word0 (s_w0),
    .word1 (s_w1),
    .ofs   (s_ofs),
    .ph    (ph)
  );

  logic signed [AMP_W-1:0] sin_v, cos_v;

  dds_sincos_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
    .clk   (clk),
    .rst   (rst),
    .ph    (ph),
    .sin_o (sin_v),
    .cos_o (cos_v)
  );

  dds_iq_mod #(.AMP_W(AMP_W), .IQ_W(IQ_W)) u_mod (
    .clk    (clk),
    .rst    (rst),
    .sleep  (sleep),
    .mod_en (mod_en),
    .sin_i  (sin_v),
    .cos_i  (cos_v),
    .iq     (s_iq),
    .dout   (dac_out)
  );

endmodule

// File: tb/dds_iq_synth_tb.sv
module dds_iq_synth_tb;

  localparam int NMAX = 4096;
  localparam int B    = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync_bypass = 1'b1;
  logic        sleep = 1'b0;
  logic        mod_en = 1'b0;
  logic        fsel = 1'b0;
  logic [31:0] tw0 = '0;
  logic [31:0] tw1 = '0;
  logic [11:0] ofs = '0;
  logic [19:0] iq = '0;
  logic [9:0]  dac_out;

  always #2 clk = ~clk;

  dds_iq_synth u_dut (
    .clk(clk), .rst(rst), .sync_bypass(sync_bypass), .sleep(sleep), .mod_en(mod_en),
    .fsel(fsel), .tword0(tw0), .tword1(tw1), .phase_ofs(ofs), .iq_word(iq),
    .dac_out(dac_out)
  );

  int    checks = 0;
  int    errors = 0;
  int    k = 0;
  bit    done = 0;
  string tag = "R1";

  logic        r_sel [NMAX];
  logic [31:0] r_w0  [NMAX];
  logic [31:0] r_w1  [NMAX];
  logic [11:0] r_ofs [NMAX];
  logic [19:0] r_iq  [NMAX];
  logic [31:0] m_tw  [NMAX];
  logic [31:0] m_acc [NMAX];
  logic [11:0] m_ofs [NMAX];
  logic [11:0] m_ph  [NMAX];
  logic [19:0] m_iq  [NMAX];

  int    exp_q[$];
  string tag_q[$];

  task automatic chk(string t, int act, int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, expv);
    end
  endtask

  // R4 table from the half-wave formula
  function automatic int sinf(int a);
    int h, u;
    longint m;
    h = a % 2048;
    u = 2 * h + 1;
    m = (longint'(4) * u * (4096 - u) * 511) / (4096 * 4096);
    return (a >= 2048) ? -int'(m) : int'(m);
  endfunction

  // R6 scaled sum with saturation
  function automatic int modv(int a, logic [19:0] w);
    int s, c, q, i, v;
    s = sinf(a);
    c = sinf((a + 1024) % 4096);
    q = $signed(w[19:10]);
    i = $signed(w[9:0]);
    v = (s * q + c * i) >>> 9;
    if (v > 511) v = 511;
    if (v < -512) v = -512;
    return v;
  endfunction

  // Driver: lets one edge pass per iteration and pushes the expected output for it
  task automatic tick(int n);
    for (int c = 0; c < n; c++) begin
      int j, es, e;
      @(posedge clk);
      j = k + B;
      r_sel[j] = fsel; r_w0[j] = tw0; r_w1[j] = tw1; r_ofs[j] = ofs; r_iq[j] = iq;
      es = sync_bypass ? j : j - 4;                     // R8 / R9 front delay
      m_tw[j]  = r_sel[es] ? r_w1[es] : r_w0[es];      // R2 select
      m_ofs[j] = r_ofs[es];
      m_iq[j]  = r_iq[es];
      m_acc[j] = sleep ? m_acc[j-1] : m_acc[j-1] + m_tw[j-1];
      m_ph[j]  = m_acc[j-1][31:20] + m_ofs[j-1];       // R3
      if (sleep)       e = 0;                          // R7
      else if (mod_en) e = modv(int'(m_ph[j-7]), m_iq[j-6]);
      else             e = sinf(int'(m_ph[j-7]));      // R5
      exp_q.push_back(e);
      tag_q.push_back(tag);
      k++;
      @(negedge clk);
    end
  endtask

  // Monitor: compares each output against the oldest expectation
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'($signed(dac_out)), e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual hung, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NMAX; i++) begin
      r_sel[i] = 0; r_w0[i] = 0; r_w1[i] = 0; r_ofs[i] = 0; r_iq[i] = 0;
      m_tw[i] = 0; m_acc[i] = 0; m_ofs[i] = 0; m_ph[i] = 0; m_iq[i] = 0;
    end
    tw0 = 32'h0123_4567;
    tw1 = 32'h0BAD_1000;
    repeat (4) begin
      @(negedge clk);
      chk("R1 reset", int'($signed(dac_out)), 0);
    end
    rst = 1'b0;
    tag = "R1 post-reset";  tick(2);
    tag = "R5 plain sine";  tick(150);
    tag = "R8 fsel high";   fsel = 1'b1; tick(40);
    tag = "R8 fsel low";    fsel = 1'b0; tick(40);
    tag = "R3 offset";      ofs = 12'h400; tick(40);
    tag = "R3 offset wrap"; ofs = 12'hC01; tick(40);
    tag = "R2 acc wrap";    tw0 = 32'hFFF0_0000; tick(100);
    tag = "R6 sine only";   tw0 = 32'h0123_4567; mod_en = 1'b1; iq = {10'h100, 10'h000}; tick(120);
    tag = "R6 mixed";       iq = {10'h338, 10'h12C}; tick(120);
    tag = "R6 sat high";    iq = {10'h1FF, 10'h1FF}; tick(200);
    tag = "R6 sat low";     iq = {10'h200, 10'h200}; tick(200);
    tag = "R7 sleep";       sleep = 1'b1; tick(30);
    tag = "R7 wake";        sleep = 1'b0; tick(40);
    tag = "R9 sync on";     sync_bypass = 1'b0; tick(40);
    tag = "R9 fsel";        fsel = 1'b1; tick(40);
    tag = "R9 offset";      ofs = 12'h123; tick(30);
    tag = "R9 iq";          iq = {10'h064, 10'h3CE}; tick(40);
    tag = "R9 plain";       mod_en = 1'b0; tick(40);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule